// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Every entry holds a virtual page number, the address-space identifier (ASID) that was current when the entry was filled, a physical page number and a permission field. A lookup hits only when both the page number and the stored ASID match the ASID currently programmed in the translation control register. As a result, translations from several address spaces can live side by side, and switching spaces does not need a flush.

On a lookup miss with no walk outstanding, the block issues one request to an external page walker. The request carries the page number and a rolling request id. The walker's response is written into the slot chosen by a round-robin pointer, tagged with the current ASID. The response is accepted only while that same request is still outstanding.

An sfence invalidates every entry whatever its ASID operand, and also squashes the outstanding walk. A change of the current ASID squashes only the outstanding walk and leaves the stored entries in place. A response that belongs to a squashed walk is dropped.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, `lk_hit` is 0 for any lookup and `walk_busy` is 0.
- R2: `lk_hit` is 1 only while `lk_valid` is 1 and a valid entry matches both `lk_vpn` and `cur_asid`. On a hit, `lk_ppn` and `lk_perm` give that entry's fields. The same page under a different current ASID misses.
- R3: A lookup miss while no walk is outstanding raises `walk_req_valid` in the same cycle, with `walk_req_vpn` equal to `lk_vpn`. `walk_busy` is 1 from the next cycle. While `walk_busy` is 1, no further request is issued.
- R4: A response (`rf_valid`) whose `rf_id` equals the id of the outstanding request writes an entry tagged with the current ASID and clears `walk_busy` on the next cycle.
- R5: When a lookup and an accepted refill fall in the same cycle, the lookup sees the contents from before the refill. The new entry hits from the next cycle on.
- R6: A cycle with `sf_valid` high invalidates all entries whatever the value of `sf_asid`, and clears `walk_busy`.
- R7: A change of `cur_asid` from one cycle to the next clears `walk_busy` but keeps every stored entry. Returning to the earlier ASID hits its entries again.
- R8: A response arriving while no walk is outstanding, or carrying an id other than the outstanding one, writes no entry. A mismatching id leaves the outstanding walk pending.
- R9: A response that arrives in the same cycle as an sfence or an ASID change is dropped.
- R10: Fills go to slots in round-robin order. After ENTRIES+1 consecutive fills, the first of them no longer hits and the others do.
- R11: Each issued request carries an id one greater (modulo 2^ID_W) than the previous request's id. The first request after reset carries id 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | ASID_W | Current address-space identifier from the translation control register |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page number of the hit |
| lk_perm | output | PERM_W | Permission bits of the hit |
| walk_req_valid | output | 1 | Walk request issued this cycle |
| walk_req_vpn | output | VPN_W | Page number to walk |
| walk_req_id | output | ID_W | Id of the issued request |
| walk_busy | output | 1 | A walk is outstanding |
| rf_valid | input | 1 | Walker response valid |
| rf_id | input | ID_W | Id echoed by the walker |
| rf_ppn | input | PPN_W | Physical page number from the walker |
| rf_perm | input | PERM_W | Permission bits from the walker |
| sf_valid | input | 1 | Sfence request |
| sf_asid | input | ASID_W | Sfence ASID operand (has no effect) |

## Verification
The assertions check, on every cycle, that only one walk is outstanding at a time and that an issued request leaves the tracker busy. They also check that request ids advance by one and that the busy flag falls only after a response, an sfence or an ASID change. Finally, they check that a hit needs an active lookup and that the cycle after an sfence neither hits nor has a walk in flight. The bench scenarios cover the effects the assertions cannot see: which entries survive an ASID switch, that stale and squashed responses leave no entry behind, that a lookup ordered against a refill in the same cycle sees the old contents, and that the round-robin pointer evicts the oldest fill.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    localparam int unsigned DEF_VPN_W   = 20;
    localparam int unsigned DEF_PPN_W   = 20;
    localparam int unsigned DEF_PERM_W  = 4;
    localparam int unsigned DEF_ASID_W  = 8;
    localparam int unsigned DEF_ID_W    = 2;
    localparam int unsigned DEF_ENTRIES = 8;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_state_e;

endpackage

// File: rtl/tlb_asid_watch.sv
module tlb_asid_watch #(
    parameter int unsigned ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              asid_moved
);

    typedef struct packed {
        logic [ASID_W-1:0] prev;
        logic              seen;
    } watch_t;

    watch_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cur_asid;
        st_d.seen = 1'b1;
        asid_moved = st_q.seen && (cur_asid != st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tlb_walk_tracker.sv
module tlb_walk_tracker
    import asid_tlb_pkg::*;
#(
    parameter int unsigned VPN_W = 20,
    parameter int unsigned ID_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic             squash,
    input  logic             rsp_valid,
    input  logic [ID_W-1:0]  rsp_id,
    output logic             req_valid,
    output logic [VPN_W-1:0] req_vpn,
    output logic [ID_W-1:0]  req_id,
    output logic             busy,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_vpn
);

    typedef struct packed {
        walk_state_e      state;
        logic [ID_W-1:0]  live_id;
        logic [ID_W-1:0]  next_id;
        logic [VPN_W-1:0] vpn;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        busy      = (st_q.state == WALK_BUSY);
        fill_en   = busy && rsp_valid && (rsp_id == st_q.live_id) && !squash;
        fill_vpn  = st_q.vpn;
        req_valid = miss && !busy && !squash;
        req_vpn   = miss_vpn;
        req_id    = st_q.next_id;

        if (squash || fill_en) begin
            st_d.state = WALK_IDLE;
        end
        if (req_valid) begin
            st_d.state   = WALK_BUSY;
            st_d.vpn     = miss_vpn;
            st_d.live_id = st_q.next_id;
            st_d.next_id = st_q.next_id + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= WALK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PPN_W   = 20,
    parameter int unsigned PERM_W  = 4,
    parameter int unsigned ASID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_all,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              any_match,
    output logic [PPN_W-1:0]  match_ppn,
    output logic [PERM_W-1:0] match_perm
);

    localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        logic [ENTRIES-1:0][PERM_W-1:0] perm;
        logic [PTR_W-1:0]               ptr;
    } arr_t;

    arr_t st_d, st_q;
    logic [ENTRIES-1:0] match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = st_q.vld[i]
                       && (st_q.vpn[i] == lk_vpn)
                       && (st_q.asid[i] == lk_asid);
    end

    always_comb begin
        any_match  = |match;
        match_ppn  = '0;
        match_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                match_ppn  = match_ppn  | st_q.ppn[i];
                match_perm = match_perm | st_q.perm[i];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (flush_all) begin
            st_d.vld = '0;
        end else if (wr_en) begin
            st_d.vld[st_q.ptr]  = 1'b1;
            st_d.vpn[st_q.ptr]  = wr_vpn;
            st_d.asid[st_q.ptr] = wr_asid;
            st_d.ppn[st_q.ptr]  = wr_ppn;
            st_d.perm[st_q.ptr] = wr_perm;
            st_d.ptr = (st_q.ptr == LAST_SLOT) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned PPN_W   = DEF_PPN_W,
    parameter int unsigned PERM_W  = DEF_PERM_W,
    parameter int unsigned ASID_W  = DEF_ASID_W,
    parameter int unsigned ID_W    = DEF_ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_perm,
    output logic              walk_req_valid,
    output logic [VPN_W-1:0]  walk_req_vpn,
    output logic [ID_W-1:0]   walk_req_id,
    output logic              walk_busy,
    input  logic              rf_valid,
    input  logic [ID_W-1:0]   rf_id,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic [PERM_W-1:0] rf_perm,
    input  logic              sf_valid,
    input  logic [ASID_W-1:0] sf_asid
);

    logic             any_match;
    logic             asid_moved;
    logic             squash;
    logic             miss;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic [ASID_W-1:0] sf_asid_unused;

    assign sf_asid_unused = sf_asid;
    assign squash = sf_valid || asid_moved;
    assign lk_hit = lk_valid && any_match;
    assign miss   = lk_valid && !any_match;

    tlb_asid_watch #(.ASID_W(ASID_W)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_asid   (cur_asid),
        .asid_moved (asid_moved)
    );

    tlb_walk_tracker #(.VPN_W(VPN_W), .ID_W(ID_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss      (miss),
        .miss_vpn  (lk_vpn),
        .squash    (squash),
        .rsp_valid (rf_valid),
        .rsp_id    (rf_id),
        .req_valid (walk_req_valid),
        .req_vpn   (walk_req_vpn),
        .req_id    (walk_req_id),
        .busy      (walk_busy),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn)
    );

    tlb_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .PERM_W  (PERM_W),
        .ASID_W  (ASID_W)
    ) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_all  (sf_valid),
        .wr_en      (fill_en),
        .wr_vpn     (fill_vpn),
        .wr_asid    (cur_asid),
        .wr_ppn     (rf_ppn),
        .wr_perm    (rf_perm),
        .lk_vpn     (lk_vpn),
        .lk_asid    (cur_asid),
        .any_match  (any_match),
        .match_ppn  (lk_ppn),
        .match_perm (lk_perm)
    );

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
    parameter int unsigned ASID_W = 8,
    parameter int unsigned ID_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ASID_W-1:0] cur_asid,
    input logic              lk_valid,
    input logic              lk_hit,
    input logic              walk_req_valid,
    input logic [ID_W-1:0]   walk_req_id,
    input logic              walk_busy,
    input logic              rf_valid,
    input logic              sf_valid
);

    logic [ASID_W-1:0] prev_asid;
    logic              seen;
    logic [ID_W-1:0]   last_id;
    logic              have_id;
    logic              moved;

    assign moved = seen && (cur_asid != prev_asid);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_asid <= '0;
            seen      <= 1'b0;
            last_id   <= '0;
            have_id   <= 1'b0;
        end else begin
            prev_asid <= cur_asid;
            seen      <= 1'b1;
            if (walk_req_valid) begin
                last_id <= walk_req_id;
                have_id <= 1'b1;
            end
        end
    end

    // R2
    a_r2_hit_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_valid);

    // R3
    a_r3_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_busy |-> !walk_req_valid);

    a_r3_issue_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |=> walk_busy);

    // R4
    a_r4_busy_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(walk_busy) |-> $past(rf_valid || sf_valid || moved));

    // R6
    a_r6_flush_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        sf_valid |=> !lk_hit);

    a_r6_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sf_valid |=> !walk_busy);

    // R7
    a_r7_switch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        moved |=> !walk_busy);

    // R11
    a_r11_id_step: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && have_id) |-> (walk_req_id == ID_W'(last_id + 1'b1)));

    a_r11_first_id: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !have_id) |-> (walk_req_id == '0));

endmodule

bind asid_tlb asid_tlb_chk #(.ASID_W(ASID_W), .ID_W(ID_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cur_asid       (cur_asid),
    .lk_valid       (lk_valid),
    .lk_hit         (lk_hit),
    .walk_req_valid (walk_req_valid),
    .walk_req_id    (walk_req_id),
    .walk_busy      (walk_busy),
    .rf_valid       (rf_valid),
    .sf_valid       (sf_valid)
);

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;

    localparam int ENTRIES = 8;
    localparam int VPN_W   = 20;
    localparam int PPN_W   = 20;
    localparam int PERM_W  = 4;
    localparam int ASID_W  = 8;
    localparam int ID_W    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ASID_W-1:0] cur_asid = '0;
    logic              lk_valid = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic              lk_hit;
    logic [PPN_W-1:0]  lk_ppn;
    logic [PERM_W-1:0] lk_perm;
    logic              walk_req_valid;
    logic [VPN_W-1:0]  walk_req_vpn;
    logic [ID_W-1:0]   walk_req_id;
    logic              walk_busy;
    logic              rf_valid = 1'b0;
    logic [ID_W-1:0]   rf_id = '0;
    logic [PPN_W-1:0]  rf_ppn = '0;
    logic [PERM_W-1:0] rf_perm = '0;
    logic              sf_valid = 1'b0;
    logic [ASID_W-1:0] sf_asid = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_id  = 0;

    always #10 clk = ~clk;

    asid_tlb #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
        .PERM_W(PERM_W), .ASID_W(ASID_W), .ID_W(ID_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
        .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
        .walk_req_id(walk_req_id), .walk_busy(walk_busy),
        .rf_valid(rf_valid), .rf_id(rf_id), .rf_ppn(rf_ppn), .rf_perm(rf_perm),
        .sf_valid(sf_valid), .sf_asid(sf_asid)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Combinational lookup with no clock edge, so no walk is launched.
    task automatic probe(string req, logic [VPN_W-1:0] vpn, bit exp_hit,
                         logic [PPN_W-1:0] exp_ppn, logic [PERM_W-1:0] exp_perm);
        lk_valid = 1'b1;
        lk_vpn   = vpn;
        #2;
        check(req, "lk_hit", lk_hit, exp_hit);
        if (exp_hit) begin
            check(req, "lk_ppn", lk_ppn, exp_ppn);
            check(req, "lk_perm", lk_perm, exp_perm);
        end
        lk_valid = 1'b0;
        #1;
    endtask

    task automatic issue(string req, logic [VPN_W-1:0] vpn, output logic [ID_W-1:0] id);
        lk_valid = 1'b1;
        lk_vpn   = vpn;
        #2;
        check(req, "walk_req_valid", walk_req_valid, 1);
        check(req, "walk_req_vpn", walk_req_vpn, vpn);
        check("R11", "walk_req_id", walk_req_id, exp_id);
        id = walk_req_id;
        exp_id = (exp_id + 1) % (1 << ID_W);
        step();
        lk_valid = 1'b0;
        #1;
        check(req, "walk_busy after issue", walk_busy, 1);
    endtask

    task automatic refill(logic [ID_W-1:0] id, logic [PPN_W-1:0] ppn, logic [PERM_W-1:0] perm);
        rf_valid = 1'b1;
        rf_id    = id;
        rf_ppn   = ppn;
        rf_perm  = perm;
        step();
        rf_valid = 1'b0;
    endtask

    task automatic fill(string req, logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn,
                        logic [PERM_W-1:0] perm);
        logic [ID_W-1:0] id;
        issue(req, vpn, id);
        refill(id, ppn, perm);
    endtask

    task automatic do_sfence(logic [ASID_W-1:0] op);
        sf_valid = 1'b1;
        sf_asid  = op;
        step();
        sf_valid = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1", "walk_busy", walk_busy, 0);
        probe("R1", 20'h00000, 0, '0, '0);
        probe("R1", 20'h12345, 0, '0, '0);
    endtask

    task automatic t_fill_hit();
        logic [ID_W-1:0] id;
        cur_asid = 8'h05;
        step();
        issue("R3", 20'h0000A, id);
        lk_valid = 1'b1; lk_vpn = 20'h0000B; #2;
        check("R3", "no second request while busy", walk_req_valid, 0);
        lk_valid = 1'b0; #1;
        refill(id, 20'hAAAA0, 4'h7);
        #1;
        check("R4", "walk_busy cleared", walk_busy, 0);
        probe("R4", 20'h0000A, 1, 20'hAAAA0, 4'h7);
        probe("R2", 20'h0000B, 0, '0, '0);
        cur_asid = 8'h06;
        step();
        probe("R2", 20'h0000A, 0, '0, '0);
        cur_asid = 8'h05;
        step();
        probe("R2", 20'h0000A, 1, 20'hAAAA0, 4'h7);
    endtask

    task automatic t_same_cycle();
        logic [ID_W-1:0] id;
        issue("R5", 20'h0000C, id);
        rf_valid = 1'b1; rf_id = id; rf_ppn = 20'hCCCC0; rf_perm = 4'h3;
        lk_valid = 1'b1; lk_vpn = 20'h0000C;
        #2;
        check("R5", "lookup sees old contents", lk_hit, 0);
        step();
        rf_valid = 1'b0; lk_valid = 1'b0;
        probe("R5", 20'h0000C, 1, 20'hCCCC0, 4'h3);
    endtask

    task automatic t_sfence();
        logic [ID_W-1:0] id;
        issue("R6", 20'h0000D, id);
        do_sfence(8'h77);
        #1;
        check("R6", "walk_busy after sfence", walk_busy, 0);
        probe("R6", 20'h0000A, 0, '0, '0);
        probe("R6", 20'h0000C, 0, '0, '0);
        refill(id, 20'hDDDD0, 4'h1);
        probe("R8", 20'h0000D, 0, '0, '0);
        fill("R6", 20'h0000A, 20'hAAAA1, 4'h5);
        do_sfence(8'h05);
        probe("R6", 20'h0000A, 0, '0, '0);
    endtask

    task automatic t_asid_switch();
        logic [ID_W-1:0] id;
        fill("R7", 20'h0000A, 20'hAAAA2, 4'h6);
        cur_asid = 8'h09;
        step();
        issue("R7", 20'h0000E, id);
        cur_asid = 8'h03;
        step();
        #1;
        check("R7", "walk_busy after ASID change", walk_busy, 0);
        refill(id, 20'hEEEE0, 4'h2);
        probe("R8", 20'h0000E, 0, '0, '0);
        cur_asid = 8'h09;
        step();
        probe("R8", 20'h0000E, 0, '0, '0);
        cur_asid = 8'h05;
        step();
        probe("R7", 20'h0000A, 1, 20'hAAAA2, 4'h6);
    endtask

    task automatic t_id_mismatch();
        logic [ID_W-1:0] id;
        issue("R8", 20'h0000F, id);
        refill(id + 1'b1, 20'hBAD00, 4'hF);
        #1;
        check("R8", "busy kept on wrong id", walk_busy, 1);
        probe("R8", 20'h0000F, 0, '0, '0);
        refill(id, 20'hFFFF0, 4'h4);
        probe("R8", 20'h0000F, 1, 20'hFFFF0, 4'h4);
    endtask

    task automatic t_squash_race();
        logic [ID_W-1:0] id;
        issue("R9", 20'h00011, id);
        rf_valid = 1'b1; rf_id = id; rf_ppn = 20'h11110; rf_perm = 4'h1;
        sf_valid = 1'b1; sf_asid = 8'h00;
        step();
        rf_valid = 1'b0; sf_valid = 1'b0;
        #1;
        check("R9", "walk_busy after sfence race", walk_busy, 0);
        probe("R9", 20'h00011, 0, '0, '0);
        issue("R9", 20'h00012, id);
        rf_valid = 1'b1; rf_id = id; rf_ppn = 20'h12120; rf_perm = 4'h2;
        cur_asid = 8'h06;
        step();
        rf_valid = 1'b0;
        cur_asid = 8'h05;
        step();
        probe("R9", 20'h00012, 0, '0, '0);
        cur_asid = 8'h06;
        step();
        probe("R9", 20'h00012, 0, '0, '0);
        cur_asid = 8'h05;
        step();
    endtask

    task automatic t_replace();
        do_sfence(8'h00);
        for (int i = 0; i <= ENTRIES; i++) begin
            fill("R10", VPN_W'(32'h100 + i), PPN_W'(32'h200 + i), PERM_W'(i));
        end
        probe("R10", 20'h00100, 0, '0, '0);
        probe("R10", 20'h00101, 1, 20'h00201, 4'h1);
        probe("R10", VPN_W'(32'h100 + ENTRIES), 1, PPN_W'(32'h200 + ENTRIES), PERM_W'(ENTRIES));
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_hit();
        t_same_cycle();
        t_sfence();
        t_asid_switch();
        t_id_mismatch();
        t_squash_race();
        t_replace();
        step();
        summary();
        $finish;
    end

endmodule